// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from reset to a programmed, idle state. It drives the chip-select, row-strobe, column-strobe, write-enable, address and bank pins, and it runs a fixed start-up order. First it holds the bus at NOP for a long settling interval. It then precharges every bank and issues two auto-refresh commands. Last, it writes a caller-supplied mode word into the device mode register. A timed gap separates each command from the next, and NOPs fill every gap.

When the mode-register settling gap has run out, the sequencer raises a done flag and keeps the bus at NOP, so a normal memory controller can take the pins over. All intervals are parameters counted in clock cycles. The settling interval is derived from the clock frequency and the hold time in microseconds. Refresh scheduling, data transfers and the data bus are not part of this block.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: During reset and for the first T_HOLD+1 clock cycles after reset is released, the pins show only NOP ({cs_n,ras_n,cas_n,we_n} = 0111). The first non-NOP command appears on the pins right after the (T_HOLD+1)-th rising edge following reset release, because the outputs are registered.
- R2: The first non-NOP command is PRECHARGE (0010), with address bit 10 high, all other address bits low and bank = 0.
- R3: The first AUTO REFRESH (0001) appears exactly T_RP cycles after the PRECHARGE.
- R4: The second AUTO REFRESH appears exactly T_RFC cycles after the first. Exactly two refresh commands are issued.
- R5: LOAD MODE (0000) appears exactly T_RFC cycles after the second refresh, with bank = 0. Address bits 9:0 carry mode_word bits 9:0 unchanged: burst length in 2:0, burst type in 3, CAS latency in 6:4, operating mode in 8:7, write-burst mode in 9.
- R6: During LOAD MODE, address bits 10 and above are 0 whatever mode_word holds there.
- R7: On every cycle that does not carry one of the four commands above, the pins show NOP with address and bank at 0. No command follows LOAD MODE.
- R8: init_done is 0 until exactly T_MRD cycles after the LOAD MODE cycle. It then stays 1 until the next reset.
- R9: Asserting reset at any point returns the pins to NOP and init_done to 0 at once. Releasing reset restarts the full sequence from the settling interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | MODE_W | Mode value written by LOAD MODE; sampled in the cycle before that command leaves |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins: all-bank flag on PRECHARGE, mode value on LOAD MODE |
| bank | output | BANK_W | Bank select, always 0 |
| init_done | output | 1 | High once the sequence has completed |

## Verification
All results are due at fixed cycle offsets from reset release. PRECHARGE lands at cycle T_HOLD+1, the refreshes at +T_RP and +T_RFC, LOAD MODE at a further +T_RFC, and init_done T_MRD cycles after that. The bench counts rising edges from a release made at a falling edge. It samples every following falling edge and compares the full pin state against the command expected for that edge number, so any command that lands one cycle early or late shows up as a mismatch on two cycles. For the reset test, the bench checks the pins immediately after reset drops mid-sequence and then replays the whole timeline from the new release.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   // Pin encoding {cs_n, ras_n, cas_n, we_n}, active low
   typedef enum logic [3:0] {
      CMD_LMR = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } sdr_cmd_e;

   typedef enum logic [3:0] {
      ST_HOLD,
      ST_PRE,
      ST_WAIT_RP,
      ST_REF1,
      ST_WAIT_RFC1,
      ST_REF2,
      ST_WAIT_RFC2,
      ST_LMR,
      ST_WAIT_MRD,
      ST_DONE
   } init_step_e;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned RST_VAL = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= CNT_W'(RST_VAL);
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // once drained, the counter must not wrap back to a large value
   assert_timer_no_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !load) |=> expired);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
   import sdram_init_pkg::*;
#(
   parameter int unsigned T_HOLD = 10000,
   parameter int unsigned T_RP   = 3,
   parameter int unsigned T_RFC  = 7,
   parameter int unsigned T_MRD  = 2,
   parameter int unsigned CNT_W  = 14
) (
   input  logic       clk,
   input  logic       rst_n,
   output init_step_e step
);

   // command state at cycle c, wait states c+1..c+T-1, next command at c+T
   localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP  - 2);
   localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(T_RFC - 2);
   localparam logic [CNT_W-1:0] MRD_LD = CNT_W'(T_MRD - 2);

   init_step_e       step_q, step_d;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;

   sdram_init_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (T_HOLD - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   always_comb begin
      step_d   = step_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (step_q)
         ST_HOLD:      if (tmr_expired) step_d = ST_PRE;
         ST_PRE: begin
            tmr_load = 1'b1;
            tmr_val  = RP_LD;
            step_d   = ST_WAIT_RP;
         end
         ST_WAIT_RP:   if (tmr_expired) step_d = ST_REF1;
         ST_REF1: begin
            tmr_load = 1'b1;
            tmr_val  = RFC_LD;
            step_d   = ST_WAIT_RFC1;
         end
         ST_WAIT_RFC1: if (tmr_expired) step_d = ST_REF2;
         ST_REF2: begin
            tmr_load = 1'b1;
            tmr_val  = RFC_LD;
            step_d   = ST_WAIT_RFC2;
         end
         ST_WAIT_RFC2: if (tmr_expired) step_d = ST_LMR;
         ST_LMR: begin
            tmr_load = 1'b1;
            tmr_val  = MRD_LD;
            step_d   = ST_WAIT_MRD;
         end
         ST_WAIT_MRD:  if (tmr_expired) step_d = ST_DONE;
         ST_DONE:      step_d = ST_DONE;
         default:      step_d = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= ST_HOLD;
      else        step_q <= step_d;
   end

   assign step = step_q;

   assert_no_rehold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q != ST_HOLD) |=> (step_q != ST_HOLD));

   assert_pre_after_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == ST_PRE) |-> ($past(step_q) == ST_HOLD));

   assert_ref2_after_ref1_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == ST_REF2) |-> ($past(step_q) == ST_WAIT_RFC1));

   assert_lmr_after_refs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == ST_LMR) |-> ($past(step_q) == ST_WAIT_RFC2));

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
   import sdram_init_pkg::*;
#(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned BANK_W = 2,
   parameter int unsigned MODE_W = 13,
   parameter int unsigned AP_BIT = 10,
   parameter int unsigned RSV_LO = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  init_step_e        step,
   input  logic [MODE_W-1:0] mode_word,
   output logic [3:0]        cmd_pins,
   output logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] bank,
   output logic              done
);

   localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << AP_BIT;

   logic [ADDR_W-1:0] lmr_addr;

   // pass defined mode fields, force reserved and surplus bits low
   for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_lmr_bit
      if (gi < RSV_LO && gi < MODE_W) begin : g_pass
         assign lmr_addr[gi] = mode_word[gi];
      end else begin : g_zero
         assign lmr_addr[gi] = 1'b0;
      end
   end

   logic [3:0]        cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= CMD_NOP;
         addr_q <= '0;
         done_q <= 1'b0;
      end else begin
         cmd_q  <= CMD_NOP;
         addr_q <= '0;
         unique case (step)
            ST_PRE: begin
               cmd_q  <= CMD_PRE;
               addr_q <= PRE_ADDR;
            end
            ST_REF1, ST_REF2: cmd_q <= CMD_REF;
            ST_LMR: begin
               cmd_q  <= CMD_LMR;
               addr_q <= lmr_addr;
            end
            ST_DONE: done_q <= 1'b1;
            default: ;
         endcase
      end
   end

   assign cmd_pins = cmd_q;
   assign addr     = addr_q;
   assign bank     = '0;
   assign done     = done_q;

   always_ff @(posedge clk) begin
      if (rst_n) begin
         assert_legal_cmd_R7: assert (cmd_q == CMD_NOP || cmd_q == CMD_PRE ||
                                      cmd_q == CMD_REF || cmd_q == CMD_LMR)
            else $error("illegal command code on pins");
      end
   end

   assert_lmr_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_LMR) |-> (addr_q[RSV_LO-1:0] == $past(mode_word[RSV_LO-1:0])));

   assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> done_q);

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
   import sdram_init_pkg::*;
#(
   parameter int unsigned CLK_MHZ = 100,
   parameter int unsigned HOLD_US = 100,
   parameter int unsigned T_HOLD  = CLK_MHZ * HOLD_US,
   parameter int unsigned T_RP    = 3,
   parameter int unsigned T_RFC   = 7,
   parameter int unsigned T_MRD   = 2,
   parameter int unsigned ADDR_W  = 13,
   parameter int unsigned BANK_W  = 2,
   parameter int unsigned MODE_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_word,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] bank,
   output logic              init_done
);

   localparam int unsigned AP_BIT = 10;
   localparam int unsigned RSV_LO = 10;
   localparam int unsigned MAX_T  = max4(T_HOLD, T_RP, T_RFC, T_MRD);
   localparam int unsigned CNT_W  = $clog2(MAX_T + 1);

   if (T_HOLD < 2 || T_RP < 2 || T_RFC < 2 || T_MRD < 2) begin : g_bad_timing
      $error("all cycle intervals must be at least 2");
   end
   if (ADDR_W <= AP_BIT) begin : g_bad_addr
      $error("ADDR_W must exceed the all-bank address bit");
   end
   if (MODE_W <= RSV_LO || MODE_W > ADDR_W) begin : g_bad_mode
      $error("MODE_W must cover the defined fields and fit the address bus");
   end

   init_step_e step;
   logic [3:0] cmd_pins;

   sdram_init_fsm #(
      .T_HOLD (T_HOLD),
      .T_RP   (T_RP),
      .T_RFC  (T_RFC),
      .T_MRD  (T_MRD),
      .CNT_W  (CNT_W)
   ) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step)
   );

   sdram_init_cmd_enc #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W),
      .MODE_W (MODE_W),
      .AP_BIT (AP_BIT),
      .RSV_LO (RSV_LO)
   ) u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .mode_word (mode_word),
      .cmd_pins  (cmd_pins),
      .addr      (addr),
      .bank      (bank),
      .done      (init_done)
   );

   assign {cs_n, ras_n, cas_n, we_n} = cmd_pins;

   // gap monitor on the pins: cycles since the last non-NOP command
   logic [CNT_W:0] gap_q;
   logic [3:0]     last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         last_q <= CMD_NOP;
      end else if (cmd_pins != CMD_NOP) begin
         gap_q  <= (CNT_W+1)'(1);
         last_q <= cmd_pins;
      end else if (gap_q != '1) begin
         gap_q  <= gap_q + 1'b1;
      end
   end

   assert_rp_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_pins == CMD_REF && last_q == CMD_PRE) |-> (gap_q == (CNT_W+1)'(T_RP)));

   assert_rfc_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_pins != CMD_NOP && last_q == CMD_REF) |-> (gap_q == (CNT_W+1)'(T_RFC)));

   assert_lmr_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_pins == CMD_LMR) |-> (addr[ADDR_W-1:RSV_LO] == '0));

   assert_done_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (last_q == CMD_LMR && gap_q == (CNT_W+1)'(T_MRD)));

endmodule

// File: tb/sdram_pwrup_seq_test.sv
module sdram_pwrup_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int TH   = 40;
   localparam int TRP  = 3;
   localparam int TRFC = 7;
   localparam int TMRD = 2;
   localparam int AW   = 13;
   localparam int BW   = 2;

   localparam int K_PRE  = TH + 1;
   localparam int K_REF1 = K_PRE + TRP;
   localparam int K_REF2 = K_REF1 + TRFC;
   localparam int K_LMR  = K_REF2 + TRFC;
   localparam int K_DONE = K_LMR + TMRD;
   localparam int K_END  = K_DONE + 60;

   localparam logic [3:0] NOP = 4'b0111;
   localparam logic [3:0] PRE = 4'b0010;
   localparam logic [3:0] REF = 4'b0001;
   localparam logic [3:0] LMR = 4'b0000;

   // {mode_word, expected address during LOAD MODE}
   localparam int NVEC = 4;
   localparam logic [2*AW-1:0] VEC [NVEC] = '{
      {13'h0032, 13'h0032},
      {13'h1FFF, 13'h03FF},
      {13'h0237, 13'h0237},
      {13'h1C88, 13'h0088}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] mode_word = '0;
   logic          cs_n, ras_n, cas_n, we_n, init_done;
   logic [AW-1:0] addr;
   logic [BW-1:0] bank;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_pwrup_seq #(
      .T_HOLD (TH),
      .T_RP   (TRP),
      .T_RFC  (TRFC),
      .T_MRD  (TMRD),
      .ADDR_W (AW),
      .BANK_W (BW),
      .MODE_W (AW)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_word (mode_word),
      .cs_n      (cs_n),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .addr      (addr),
      .bank      (bank),
      .init_done (init_done)
   );

   task automatic check(input string req, input logic [3:0] c, input logic [AW-1:0] a,
                        input logic d);
      total++;
      if ({cs_n, ras_n, cas_n, we_n} !== c || addr !== a || bank !== '0 || init_done !== d) begin
         bad++;
         $display("FAIL %s: cmd=%b addr=%h bank=%h done=%b expected cmd=%b addr=%h bank=0 done=%b",
                  req, {cs_n, ras_n, cas_n, we_n}, addr, bank, init_done, c, a, d);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R9 reset", NOP, '0, 1'b0);
      repeat (2) @(negedge clk);
      check("R9 reset hold", NOP, '0, 1'b0);
      rst_n = 1'b1;
   endtask

   // walk edges 1..last after a release at a falling edge
   task automatic run_timeline(input logic [AW-1:0] lmr_a, input int last);
      for (int k = 1; k <= last; k++) begin
         logic [3:0]    ec;
         logic [AW-1:0] ea;
         string         rq;
         @(posedge clk);
         @(negedge clk);
         ec = NOP; ea = '0; rq = "R7 idle";
         if (k < K_PRE)        rq = "R1 hold";
         else if (k == K_PRE)  begin ec = PRE; ea = AW'(1) << 10; rq = "R2 precharge"; end
         else if (k == K_REF1) begin ec = REF; rq = "R3 refresh1"; end
         else if (k == K_REF2) begin ec = REF; rq = "R4 refresh2"; end
         else if (k == K_LMR)  begin ec = LMR; ea = lmr_a; rq = "R5 R6 load mode"; end
         else if (k >= K_DONE) rq = "R8 done";
         check(rq, ec, ea, k >= K_DONE);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!ended) begin
         ended = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // table walk: full sequence for each mode word
      for (int v = 0; v < NVEC; v++) begin
         mode_word = VEC[v][2*AW-1:AW];
         do_reset();
         run_timeline(VEC[v][AW-1:0], K_END);
      end

      // R9: reset between the two refreshes, then a full restart
      mode_word = 13'h0021;
      do_reset();
      run_timeline(13'h0021, K_REF1 + 2);
      do_reset();
      run_timeline(13'h0021, K_END);

      // R9 / R8: reset after done drops the flag and restarts the hold
      do_reset();
      run_timeline(13'h0021, K_PRE - 1);

      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule